// File: doc/BRIEF.md
# Timer Interrupt Line Router

This block sits between a bank of timer channels and the interrupt controller of the chip. Each timer channel hands it an assert request, a deassert request, an interrupt enable, a trigger type (level or edge) and a 5-bit route field. The block turns these into activity on a bank of 32 registered interrupt lines. Two legacy sources are also merged into the same bank: an interval-timer interrupt and a clock-chip interrupt.

A legacy steering bit changes where things go. While it is set, timers 0 and 1 move to fixed lines and both legacy sources are cut off. The block also drives an enable output back to the external interval timer. Switching the steering bit on or off produces one cycle of forced line values. When the bit is turned off, line 8 is restored from the last recorded clock-chip level.

Top module: `irq_route_sel`

## Requirements
- R1: Reset drives all 32 lines of `irq_o` low and drives `pit_en_o` high.
- R2: A level-type timer (trigger bit 1) with an accepted assert request drives its line high one cycle after the request. The line stays high until a deassert request arrives, and drops one cycle after that request.
- R3: An edge-type timer (trigger bit 0) with an accepted assert request drives its line high for exactly one cycle, starting one cycle after the request.
- R4: An assert request is accepted only while both the timer's interrupt enable and `glb_en_i` are high. Otherwise the timer contributes nothing to any line.
- R5: Timer t's route field is `tmr_route_i[5t+4:5t]` and names its line by number. Timers 2 and up always use this field. Timers 0 and 1 use it while `legacy_mode_i` is low.
- R6: While `legacy_mode_i` is high, timer 0 drives line 0 and timer 1 drives line 8, regardless of their route fields.
- R7: While `legacy_mode_i` is low, `pit_irq_i` appears on line 0 and `rtc_irq_i` appears on line 8, each one cycle later. While it is high, both inputs are blocked.
- R8: In the cycle after `legacy_mode_i` rises, lines 0 and 8 are low and `pit_en_o` is low. `pit_en_o` stays low while the mode holds.
- R9: In the cycle after `legacy_mode_i` falls, line 0 is low, `pit_en_o` is high, and line 8 equals the recorded clock-chip level. That level is sampled every cycle, including while the input is blocked.
- R10: A line driven by several sources is the OR of them. Releasing one source leaves the line high while another source still drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_mode_i | input | 1 | Legacy steering bit |
| tmr_set_i | input | NUM_TIMERS | Per-timer assert request |
| tmr_clr_i | input | NUM_TIMERS | Per-timer deassert request |
| tmr_ie_i | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_level_i | input | NUM_TIMERS | Per-timer trigger type, 1 = level, 0 = edge |
| tmr_route_i | input | 5*NUM_TIMERS | Per-timer route fields, timer t at bits 5t+4:5t |
| pit_irq_i | input | 1 | Interval-timer interrupt input |
| rtc_irq_i | input | 1 | Clock-chip interrupt input |
| irq_o | output | 32 | Registered interrupt lines |
| pit_en_o | output | 1 | Interval-timer enable |

## Verification
The assertions check the steering-bit edges on every cycle: the state of `pit_en_o` after each edge, the forced low on line 0 and line 8 at entry, and the forced low on line 0 at exit. They also check that the bank stays silent while the global enable is low and steering is on, and that line 0 follows the interval-timer input in normal mode. The bench scenarios cover behaviour that needs a chosen history: level hold and release, the length of an edge pulse, route fields moving between lines, OR-merging of shared lines, and restoring line 8 from a clock-chip level recorded while that input was blocked.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NUM_LINES  = 32;
  localparam int unsigned ROUTE_W    = $clog2(NUM_LINES);
  localparam int unsigned LEG_LINE_A = 0;
  localparam int unsigned LEG_LINE_B = 8;
  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/irq_hold_cell.sv
module irq_hold_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic glb_en_i,
  input  logic level_i,
  output logic active_o
);
  logic en, fire, held_q, held_d;

  assign en   = ie_i & glb_en_i;
  assign fire = set_i & en;

  always_comb begin
    if (!level_i)            held_d = 1'b0;
    else if (fire)           held_d = 1'b1;
    else if (set_i || clr_i) held_d = 1'b0;
    else                     held_d = held_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= held_d;
  end

  // next-state view so the registered line follows the request by one cycle
  assign active_o = en & (held_d | (fire & ~level_i));
endmodule

// File: rtl/irq_route_steer.sv
module irq_route_steer
  import irq_route_pkg::*;
#(
  parameter int unsigned TIMER_IDX = 0
) (
  input  logic [ROUTE_W-1:0] route_i,
  input  logic               legacy_i,
  input  logic               active_i,
  output line_vec_t          lines_o
);
  logic [ROUTE_W-1:0] sel;

  generate
    if (TIMER_IDX == 0) begin : g_fix_a
      assign sel = legacy_i ? ROUTE_W'(LEG_LINE_A) : route_i;
    end else if (TIMER_IDX == 1) begin : g_fix_b
      assign sel = legacy_i ? ROUTE_W'(LEG_LINE_B) : route_i;
    end else begin : g_free
      logic unused_leg;
      assign unused_leg = legacy_i;
      assign sel = route_i;
    end
  endgenerate

  always_comb begin
    lines_o      = '0;
    lines_o[sel] = active_i;
  end
endmodule

// File: rtl/irq_legacy_gate.sv
module irq_legacy_gate
  import irq_route_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      legacy_i,
  input  logic      pit_i,
  input  logic      rtc_i,
  output logic      enter_o,
  output logic      exit_o,
  output logic      rtc_lvl_o,
  output logic      pit_en_o,
  output line_vec_t pass_o
);
  logic leg_q, rtc_q, pit_en_q;

  assign enter_o = legacy_i & ~leg_q;
  assign exit_o  = ~legacy_i & leg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q    <= 1'b0;
      rtc_q    <= 1'b0;
      pit_en_q <= 1'b1;
    end else begin
      leg_q <= legacy_i;
      rtc_q <= rtc_i;
      if (enter_o)     pit_en_q <= 1'b0;
      else if (exit_o) pit_en_q <= 1'b1;
    end
  end

  always_comb begin
    pass_o = '0;
    if (!legacy_i) begin
      pass_o[LEG_LINE_A] = pit_i;
      pass_o[LEG_LINE_B] = rtc_i;
    end
  end

  assign rtc_lvl_o = rtc_q;
  assign pit_en_o  = pit_en_q;
endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          glb_en_i,
  input  logic                          legacy_mode_i,
  input  logic [NUM_TIMERS-1:0]         tmr_set_i,
  input  logic [NUM_TIMERS-1:0]         tmr_clr_i,
  input  logic [NUM_TIMERS-1:0]         tmr_ie_i,
  input  logic [NUM_TIMERS-1:0]         tmr_level_i,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route_i,
  input  logic                          pit_irq_i,
  input  logic                          rtc_irq_i,
  output logic [NUM_LINES-1:0]          irq_o,
  output logic                          pit_en_o
);
  line_vec_t tmr_lines [NUM_TIMERS];
  line_vec_t pass_lines, lines_d, irq_q;
  logic      enter, leave, rtc_lvl;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic active;
    irq_hold_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (tmr_set_i[t]),
      .clr_i    (tmr_clr_i[t]),
      .ie_i     (tmr_ie_i[t]),
      .glb_en_i (glb_en_i),
      .level_i  (tmr_level_i[t]),
      .active_o (active)
    );
    irq_route_steer #(.TIMER_IDX(t)) u_steer (
      .route_i  (tmr_route_i[t*ROUTE_W +: ROUTE_W]),
      .legacy_i (legacy_mode_i),
      .active_i (active),
      .lines_o  (tmr_lines[t])
    );
  end

  irq_legacy_gate u_leg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .legacy_i  (legacy_mode_i),
    .pit_i     (pit_irq_i),
    .rtc_i     (rtc_irq_i),
    .enter_o   (enter),
    .exit_o    (leave),
    .rtc_lvl_o (rtc_lvl),
    .pit_en_o  (pit_en_o),
    .pass_o    (pass_lines)
  );

  always_comb begin
    lines_d = pass_lines;
    for (int t = 0; t < NUM_TIMERS; t++) lines_d = lines_d | tmr_lines[t];
    // one cycle of forced values on mode edges
    if (enter) begin
      lines_d[LEG_LINE_A] = 1'b0;
      lines_d[LEG_LINE_B] = 1'b0;
    end else if (leave) begin
      lines_d[LEG_LINE_A] = 1'b0;
      lines_d[LEG_LINE_B] = rtc_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= lines_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_route_sel_chk.sv
module irq_route_sel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        glb_en_i,
  input logic        legacy_mode_i,
  input logic        pit_irq_i,
  input logic [31:0] irq_o,
  input logic        pit_en_o
);
  // R8
  pit_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(legacy_mode_i) |=> !pit_en_o);

  // R8
  enter_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(legacy_mode_i) |=> (!irq_o[0] && !irq_o[8]));

  // R9
  pit_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(legacy_mode_i) |=> pit_en_o);

  // R9
  exit_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(legacy_mode_i) |=> !irq_o[0]);

  // R4
  quiet_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_mode_i && !glb_en_i) |=> (irq_o == 32'h0));

  // R7
  pit_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_mode_i && !$past(legacy_mode_i) && !glb_en_i) |=> (irq_o[0] == $past(pit_irq_i)));
endmodule

bind irq_route_sel irq_route_sel_chk u_chk (.*);

// File: tb/sim_irq_route_sel.sv
module sim_irq_route_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          glb_en_i = 1'b0;
  logic          legacy_mode_i = 1'b0;
  logic [NT-1:0] tmr_set_i = '0, tmr_clr_i = '0, tmr_ie_i = '0, tmr_level_i = '0;
  logic [NT*5-1:0] tmr_route_i = '0;
  logic          pit_irq_i = 1'b0, rtc_irq_i = 1'b0;
  logic [31:0]   irq_o;
  logic          pit_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  irq_route_sel #(.NUM_TIMERS(NT)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input int t, input logic [4:0] r, input logic lvl, input logic ie);
    tmr_route_i[t*5 +: 5] = r;
    tmr_level_i[t] = lvl;
    tmr_ie_i[t] = ie;
  endtask

  task automatic pulse_set(input logic [NT-1:0] m);
    tmr_set_i = m; tick(); tmr_set_i = '0;
  endtask

  task automatic pulse_clr(input logic [NT-1:0] m);
    tmr_clr_i = m; tick(); tmr_clr_i = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq_o, 32'h0);
    check("R1 pit_en", {31'h0, pit_en_o}, 32'h1);
  endtask

  task automatic t_level();
    glb_en_i = 1'b1;
    cfg(2, 5'd5, 1'b1, 1'b1);
    pulse_set(4'b0100);
    check("R2 raise", irq_o, 32'h20);
    tick(); tick();
    check("R2 hold", irq_o, 32'h20);
    pulse_clr(4'b0100);
    check("R2 release", irq_o, 32'h0);
  endtask

  task automatic t_edge();
    cfg(3, 5'd7, 1'b0, 1'b1);
    pulse_set(4'b1000);
    check("R3 pulse", irq_o, 32'h80);
    tick();
    check("R3 one cycle", irq_o, 32'h0);
  endtask

  task automatic t_gate();
    cfg(2, 5'd5, 1'b1, 1'b0);
    pulse_set(4'b0100);
    check("R4 ie low", irq_o, 32'h0);
    cfg(2, 5'd5, 1'b1, 1'b1);
    glb_en_i = 1'b0;
    pulse_set(4'b0100);
    check("R4 glb low", irq_o, 32'h0);
    glb_en_i = 1'b1;
    tick();
    check("R4 nothing held", irq_o, 32'h0);
  endtask

  task automatic t_or();
    cfg(2, 5'd20, 1'b1, 1'b1);
    cfg(3, 5'd20, 1'b1, 1'b1);
    pulse_set(4'b1100);
    check("R10 both", irq_o, 32'h0010_0000);
    pulse_clr(4'b0100);
    check("R10 one left", irq_o, 32'h0010_0000);
    pulse_clr(4'b1000);
    check("R10 none", irq_o, 32'h0);
  endtask

  task automatic t_legacy_route();
    cfg(0, 5'd3, 1'b1, 1'b1);
    cfg(1, 5'd3, 1'b1, 1'b1);
    cfg(2, 5'd12, 1'b1, 1'b1);
    pulse_set(4'b0111);
    check("R5 routes", irq_o, 32'h0000_1008);
    legacy_mode_i = 1'b1;
    tick();
    check("R8 enter force", irq_o, 32'h0000_1000);
    check("R8 pit_en off", {31'h0, pit_en_o}, 32'h0);
    tick();
    check("R6 fixed lines", irq_o, 32'h0000_1101);
    check("R8 pit_en stays", {31'h0, pit_en_o}, 32'h0);
    legacy_mode_i = 1'b0;
    tick();
    check("R9 exit", irq_o, 32'h0000_1008);
    check("R9 pit_en on", {31'h0, pit_en_o}, 32'h1);
    pulse_clr(4'b0111);
    check("R2 cleared", irq_o, 32'h0);
  endtask

  task automatic t_passthru();
    glb_en_i = 1'b0;
    pit_irq_i = 1'b1;
    tick();
    check("R7 pit pass", irq_o, 32'h1);
    rtc_irq_i = 1'b1;
    tick();
    check("R7 rtc pass", irq_o, 32'h101);
    pit_irq_i = 1'b0; rtc_irq_i = 1'b0;
    legacy_mode_i = 1'b1;
    tick(); tick();
    pit_irq_i = 1'b1;
    tick();
    check("R7 blocked", irq_o, 32'h0);
    rtc_irq_i = 1'b1;
    tick();
    check("R7 rtc blocked", irq_o, 32'h0);
    legacy_mode_i = 1'b0;
    tick();
    check("R9 restore rtc", irq_o, 32'h100);
    tick();
    check("R7 resume", irq_o, 32'h101);
    pit_irq_i = 1'b0; rtc_irq_i = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_level();
    t_edge();
    t_gate();
    t_or();
    t_legacy_route();
    t_passthru();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule